// File: doc/BRIEF.md
# ECP Peripheral Link Engine

This block is the peripheral end of an ECP parallel port link. It watches the host's strobe, acknowledge and direction-request lines, drives the peripheral's strobe, acknowledge and direction-acknowledge lines, and controls when it drives the eight data lines through a separate output-enable. On the local side it has two valid/ready ports. One hands over each byte the host sends, with a flag that marks it as a command (channel address) or as data. The other takes a byte and a command flag for sending back to the host.

A single state machine serves both directions. The level of the host's direction-request line decides which one is active. When the host turns the bus around while a forward byte is still expected, the block gives up that byte and enters reverse handling. A byte offered for sending while the host is still in forward phase is not taken: the local side keeps it pending and the bus stays released. When the host takes the bus back in the middle of a reverse byte, the block releases all lines at once and emits a one-cycle abort pulse. Every host line and the data bus pass through a synchroniser chain, SYNC_STAGES flops deep, before the state machine uses them.

Top module: `ecp_periph_link`

## Requirements
- R1: During and after reset, periph_clk_o is 1, periph_ack_o is 0, ack_rev_n_o is 1, ecp_data_oe is 0 and rx_valid_o is 0.
- R2: With the default SYNC_STAGES of 2, a change on a host input first shows on the outputs at the third rising clock edge after the change, and not before it.
- R3: In forward phase (rev_req_n_i high) with no unread byte held, host_clk_i going low raises periph_ack_o. When host_clk_i returns high, the block captures ecp_data_i, drops periph_ack_o and raises rx_valid_o with that byte on rx_byte_o.
- R4: rx_cmd_o is 0 when host_ack_i was high at capture (a data byte) and 1 when host_ack_i was low (a command byte).
- R5: While rx_valid_o is high and rx_ready_i is low, rx_byte_o and rx_cmd_o hold their values, and periph_ack_o stays low even if host_clk_i is low.
- R6: rev_req_n_i going low in forward phase drives ack_rev_n_o low. ecp_data_oe stays 0 until a byte is accepted on the transmit port.
- R7: If rev_req_n_i goes low while periph_ack_o is high for a forward byte, periph_ack_o drops, ack_rev_n_o goes low and no byte is delivered.
- R8: tx_ready_o stays 0 and ecp_data_oe stays 0 while rev_req_n_i is high, so a pending transmit byte waits and is not driven.
- R9: At the first clock edge where tx_valid_i and tx_ready_o are both high, the block drives tx_byte_i on ecp_data_o with ecp_data_oe high and sets periph_ack_o to the inverse of tx_cmd_i (1 for data, 0 for command). At the next edge periph_clk_o goes low. host_ack_i going high returns periph_clk_o high.
- R10: After host_ack_i falls to end a reverse byte, ecp_data_oe goes to 0, periph_ack_o to 0 and ack_rev_n_o to 1.
- R11: If rev_req_n_i returns high during a reverse byte, the block sets ecp_data_oe to 0, periph_clk_o to 1, periph_ack_o to 0 and ack_rev_n_o to 1, and raises rev_abort_o for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecp_data_i | input | DATA_W | Data lines as seen from the pad |
| ecp_data_o | output | DATA_W | Value driven on the data lines |
| ecp_data_oe | output | 1 | Data line output enable |
| host_clk_i | input | 1 | Host strobe, active low |
| host_ack_i | input | 1 | Host acknowledge / forward data-command flag |
| rev_req_n_i | input | 1 | Host direction request, low asks for reverse |
| periph_clk_o | output | 1 | Peripheral strobe, active low |
| periph_ack_o | output | 1 | Peripheral acknowledge / reverse data-command flag |
| ack_rev_n_o | output | 1 | Reverse direction acknowledge, active low |
| rx_valid_o | output | 1 | Received byte available |
| rx_ready_i | input | 1 | Local side takes the received byte |
| rx_byte_o | output | DATA_W | Received byte |
| rx_cmd_o | output | 1 | Received byte is a command |
| tx_valid_i | input | 1 | Byte offered for reverse transfer |
| tx_ready_o | output | 1 | Block takes the offered byte |
| tx_byte_i | input | DATA_W | Byte to send |
| tx_cmd_i | input | 1 | Byte to send is a command |
| rev_abort_o | output | 1 | One-cycle pulse: reverse byte abandoned |

## Verification
A host line change passes two synchroniser flops and the state register, so every host-triggered output is due at the third rising edge after the change. The bench drives host lines on falling edges. It samples one falling edge before that third edge to confirm the old value is still present, and at the falling edge just after it for the new value. A transmit byte offered while tx_ready_o is high shows on the bus one edge later, and periph_clk_o falls one edge after that. Received bytes are checked by a monitor against a queue that the forward driver fills, with samples taken just after each falling edge, where they match the values the next rising edge sees.

// File: rtl/ecp_link_pkg.sv
package ecp_link_pkg;
   typedef enum logic [2:0] {
      ST_FWD_IDLE,
      ST_FWD_ACKED,
      ST_REV_IDLE,
      ST_REV_SETUP,
      ST_REV_STROBE,
      ST_REV_FINISH
   } link_state_t;
endpackage

// File: rtl/ecp_sync.sv
module ecp_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   initial assert (STAGES >= 2) else $error("ecp_sync: STAGES must be at least 2");
   initial assert (W >= 1) else $error("ecp_sync: W must be positive");

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] r;
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) r <= RST_VAL;
            else        r <= d_i;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) r <= RST_VAL;
            else        r <= g_stage[g-1].r;
      end
   end

   assign q_o = g_stage[STAGES-1].r;
endmodule

// File: rtl/ecp_link_fsm.sv
module ecp_link_fsm
   import ecp_link_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hclk_s,
   input  logic              hack_s,
   input  logic              rrq_s,
   input  logic [DATA_W-1:0] data_s,
   output logic              periph_clk_o,
   output logic              periph_ack_o,
   output logic              ack_rev_n_o,
   output logic [DATA_W-1:0] bus_o,
   output logic              bus_oe_o,
   output logic              rx_valid_o,
   input  logic              rx_ready_i,
   output logic [DATA_W-1:0] rx_byte_o,
   output logic              rx_cmd_o,
   input  logic              tx_valid_i,
   output logic              tx_ready_o,
   input  logic [DATA_W-1:0] tx_byte_i,
   input  logic              tx_cmd_i,
   output logic              rev_abort_o
);
   link_state_t state;
   logic        in_rev_byte;

   assign tx_ready_o  = (state == ST_REV_IDLE) && !rrq_s;
   assign in_rev_byte = (state == ST_REV_SETUP) || (state == ST_REV_STROBE) ||
                        (state == ST_REV_FINISH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_FWD_IDLE;
         periph_clk_o <= 1'b1;
         periph_ack_o <= 1'b0;
         ack_rev_n_o  <= 1'b1;
         bus_o        <= '0;
         bus_oe_o     <= 1'b0;
         rx_valid_o   <= 1'b0;
         rx_byte_o    <= '0;
         rx_cmd_o     <= 1'b0;
         rev_abort_o  <= 1'b0;
      end else begin
         rev_abort_o <= 1'b0;
         if (rx_valid_o && rx_ready_i) rx_valid_o <= 1'b0;
         if (in_rev_byte && rrq_s) begin
            bus_oe_o     <= 1'b0;
            periph_clk_o <= 1'b1;
            periph_ack_o <= 1'b0;
            ack_rev_n_o  <= 1'b1;
            rev_abort_o  <= 1'b1;
            state        <= ST_FWD_IDLE;
         end else begin
            unique case (state)
               ST_FWD_IDLE: begin
                  if (!rrq_s) begin
                     ack_rev_n_o <= 1'b0;
                     state       <= ST_REV_IDLE;
                  end else if (!hclk_s && !rx_valid_o) begin
                     periph_ack_o <= 1'b1;
                     state        <= ST_FWD_ACKED;
                  end
               end
               ST_FWD_ACKED: begin
                  if (!rrq_s) begin
                     periph_ack_o <= 1'b0;
                     ack_rev_n_o  <= 1'b0;
                     state        <= ST_REV_IDLE;
                  end else if (hclk_s) begin
                     rx_byte_o    <= data_s;
                     rx_cmd_o     <= !hack_s;
                     rx_valid_o   <= 1'b1;
                     periph_ack_o <= 1'b0;
                     state        <= ST_FWD_IDLE;
                  end
               end
               ST_REV_IDLE: begin
                  if (rrq_s) begin
                     ack_rev_n_o <= 1'b1;
                     state       <= ST_FWD_IDLE;
                  end else if (tx_valid_i) begin
                     bus_o        <= tx_byte_i;
                     bus_oe_o     <= 1'b1;
                     periph_ack_o <= !tx_cmd_i;
                     state        <= ST_REV_SETUP;
                  end
               end
               ST_REV_SETUP: begin
                  periph_clk_o <= 1'b0;
                  state        <= ST_REV_STROBE;
               end
               ST_REV_STROBE: begin
                  if (hack_s) begin
                     periph_clk_o <= 1'b1;
                     state        <= ST_REV_FINISH;
                  end
               end
               ST_REV_FINISH: begin
                  if (!hack_s) begin
                     bus_oe_o     <= 1'b0;
                     periph_ack_o <= 1'b0;
                     ack_rev_n_o  <= 1'b1;
                     state        <= ST_FWD_IDLE;
                  end
               end
               default: state <= ST_FWD_IDLE;
            endcase
         end
      end
   end

   // R6: the bus is driven only while reverse direction is acknowledged
   a_r6_drive_only_reversed: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe_o |-> !ack_rev_n_o);
   // R9: the strobe falls only with data already on the bus
   a_r9_strobe_after_data: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(periph_clk_o) |-> bus_oe_o && $past(bus_oe_o));
   // R10: handing the bus back releases the lines together
   a_r10_release_together: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_rev_n_o) |-> !bus_oe_o && !periph_ack_o && periph_clk_o);
   // R5: an unread byte stays put
   a_r5_hold_unread: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o && !rx_ready_i |=> rx_valid_o && $stable(rx_byte_o) && $stable(rx_cmd_o));
   // R3: a delivered byte follows an acknowledge that has just dropped
   a_r3_ack_before_byte: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_valid_o) |-> $past(periph_ack_o) && !periph_ack_o);
   // R11: the abort pulse lasts one cycle and comes with released lines
   a_r11_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rev_abort_o |-> !bus_oe_o && periph_clk_o ##1 !rev_abort_o);
   // R7: turnaround during a forward wait drops the acknowledge
   a_r7_timeout: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FWD_ACKED) && !rrq_s |=> !periph_ack_o && !ack_rev_n_o);
endmodule

// File: rtl/ecp_periph_link.sv
module ecp_periph_link #(
   parameter int DATA_W = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] ecp_data_i,
   output logic [DATA_W-1:0] ecp_data_o,
   output logic              ecp_data_oe,
   input  logic              host_clk_i,
   input  logic              host_ack_i,
   input  logic              rev_req_n_i,
   output logic              periph_clk_o,
   output logic              periph_ack_o,
   output logic              ack_rev_n_o,
   output logic              rx_valid_o,
   input  logic              rx_ready_i,
   output logic [DATA_W-1:0] rx_byte_o,
   output logic              rx_cmd_o,
   input  logic              tx_valid_i,
   output logic              tx_ready_o,
   input  logic [DATA_W-1:0] tx_byte_i,
   input  logic              tx_cmd_i,
   output logic              rev_abort_o
);
   localparam int SYNC_W = DATA_W + 3;
   localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, 1'b0, 1'b1, {DATA_W{1'b0}}};

   initial assert (DATA_W >= 1) else $error("ecp_periph_link: DATA_W must be positive");

   logic [SYNC_W-1:0] raw_in, sync_out;
   logic              hclk_s, hack_s, rrq_s;
   logic [DATA_W-1:0] data_s;

   assign raw_in = {rev_req_n_i, host_ack_i, host_clk_i, ecp_data_i};
   assign {rrq_s, hack_s, hclk_s, data_s} = sync_out;

   ecp_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) i_sync (
      .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(sync_out));

   ecp_link_fsm #(.DATA_W(DATA_W)) i_fsm (
      .clk(clk), .rst_n(rst_n),
      .hclk_s(hclk_s), .hack_s(hack_s), .rrq_s(rrq_s), .data_s(data_s),
      .periph_clk_o(periph_clk_o), .periph_ack_o(periph_ack_o), .ack_rev_n_o(ack_rev_n_o),
      .bus_o(ecp_data_o), .bus_oe_o(ecp_data_oe),
      .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i), .rx_byte_o(rx_byte_o),
      .rx_cmd_o(rx_cmd_o),
      .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o), .tx_byte_i(tx_byte_i),
      .tx_cmd_i(tx_cmd_i), .rev_abort_o(rev_abort_o));
endmodule

// File: tb/test_ecp_periph_link.sv
`timescale 1ns/1ps
module test_ecp_periph_link;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] ecp_data_i = 8'h00;
   logic [7:0] ecp_data_o;
   logic       ecp_data_oe;
   logic       host_clk_i = 1'b1, host_ack_i = 1'b0, rev_req_n_i = 1'b1;
   logic       periph_clk_o, periph_ack_o, ack_rev_n_o;
   logic       rx_valid_o, rx_ready_i = 1'b1, rx_cmd_o;
   logic [7:0] rx_byte_o;
   logic       tx_valid_i = 1'b0, tx_ready_o, tx_cmd_i = 1'b0, rev_abort_o;
   logic [7:0] tx_byte_i = 8'h00;

   int vectors = 0, fails = 0;
   logic [8:0] rx_q[$];
   logic [8:0] tx_q[$];

   always #2 clk = ~clk;

   ecp_periph_link i_ecp_periph_link (
      .clk(clk), .rst_n(rst_n), .ecp_data_i(ecp_data_i), .ecp_data_o(ecp_data_o),
      .ecp_data_oe(ecp_data_oe), .host_clk_i(host_clk_i), .host_ack_i(host_ack_i),
      .rev_req_n_i(rev_req_n_i), .periph_clk_o(periph_clk_o), .periph_ack_o(periph_ack_o),
      .ack_rev_n_o(ack_rev_n_o), .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i),
      .rx_byte_o(rx_byte_o), .rx_cmd_o(rx_cmd_o), .tx_valid_i(tx_valid_i),
      .tx_ready_o(tx_ready_o), .tx_byte_i(tx_byte_i), .tx_cmd_i(tx_cmd_i),
      .rev_abort_o(rev_abort_o));

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   // receive monitor: pops the scoreboard on each handshake
   always begin
      @(negedge clk);
      #1;
      if (rst_n && rx_valid_o && rx_ready_i) begin
         if (rx_q.size() == 0)
            chk(1'b0, "R3", "unexpected rx byte", {rx_cmd_o, rx_byte_o}, 0);
         else begin
            logic [8:0] e;
            e = rx_q.pop_front();
            chk({rx_cmd_o, rx_byte_o} == e, "R4", "rx cmd/byte",
                {rx_cmd_o, rx_byte_o}, e);
         end
      end
   end

   // forward driver: pushes the expected item, then runs the host strobe
   task automatic fwd_byte(input logic [7:0] b, input logic cmd, input bit exact);
      int n;
      rx_q.push_back({cmd, b});
      ecp_data_i = b;
      host_ack_i = !cmd;
      host_clk_i = 1'b0;
      if (exact) begin
         step(2);
         chk(periph_ack_o == 1'b0, "R2", "ack too early", periph_ack_o, 0);
         step(1);
         chk(periph_ack_o == 1'b1, "R2", "ack at third edge", periph_ack_o, 1);
      end else begin
         n = 0;
         while (periph_ack_o !== 1'b1 && n < 100) begin step(1); n++; end
         chk(periph_ack_o == 1'b1, "R3", "periph ack rise", periph_ack_o, 1);
      end
      host_clk_i = 1'b1;
      step(3);
      chk(periph_ack_o == 1'b0, "R3", "periph ack drop", periph_ack_o, 0);
      ecp_data_i = 8'h00;
      step(1);
   endtask

   // transmit driver: holds the offer until it is taken
   task automatic tx_push(input logic [7:0] b, input logic cmd);
      tx_q.push_back({cmd, b});
      tx_byte_i  = b;
      tx_cmd_i   = cmd;
      tx_valid_i = 1'b1;
      forever begin
         #1;
         if (tx_ready_o) break;
         @(negedge clk);
      end
      @(negedge clk);
      tx_valid_i = 1'b0;
   endtask

   // host side of one reverse byte
   task automatic rev_host;
      int n;
      logic [8:0] e;
      n = 0;
      while (periph_clk_o !== 1'b0 && n < 100) begin step(1); n++; end
      chk(periph_clk_o == 1'b0, "R9", "periph clk low", periph_clk_o, 0);
      chk(ecp_data_oe == 1'b1, "R9", "bus driven", ecp_data_oe, 1);
      e = tx_q.pop_front();
      chk(ecp_data_o == e[7:0], "R9", "reverse byte", ecp_data_o, e[7:0]);
      chk(periph_ack_o == !e[8], "R9", "data/command flag", periph_ack_o, !e[8]);
      host_ack_i = 1'b1;
      step(2);
      chk(periph_clk_o == 1'b0, "R9", "periph clk held", periph_clk_o, 0);
      step(1);
      chk(periph_clk_o == 1'b1, "R9", "periph clk high", periph_clk_o, 1);
      host_ack_i = 1'b0;
      step(3);
      chk(ecp_data_oe == 1'b0, "R10", "bus released", ecp_data_oe, 0);
      chk(periph_ack_o == 1'b0, "R10", "periph ack low", periph_ack_o, 0);
      chk(ack_rev_n_o == 1'b1, "R10", "ack reverse high", ack_rev_n_o, 1);
      step(2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "WD", "watchdog expired", 0, 1);
      summary();
   end

   initial begin
      step(2);
      // R1 reset levels
      chk(periph_clk_o == 1'b1, "R1", "periph clk reset", periph_clk_o, 1);
      chk(periph_ack_o == 1'b0, "R1", "periph ack reset", periph_ack_o, 0);
      chk(ack_rev_n_o == 1'b1, "R1", "ack reverse reset", ack_rev_n_o, 1);
      chk(ecp_data_oe == 1'b0, "R1", "bus oe reset", ecp_data_oe, 0);
      chk(rx_valid_o == 1'b0, "R1", "rx valid reset", rx_valid_o, 0);
      rst_n = 1'b1;
      step(3);
      chk(periph_clk_o == 1'b1 && ack_rev_n_o == 1'b1, "R1", "levels after reset",
          {periph_clk_o, ack_rev_n_o}, 3);

      // R2 R3 R4 forward data and command bytes
      fwd_byte(8'hA5, 1'b0, 1'b1);
      fwd_byte(8'h3C, 1'b1, 1'b0);
      fwd_byte(8'h00, 1'b0, 1'b0);

      // R5 back-pressure on the receive port
      rx_ready_i = 1'b0;
      fwd_byte(8'h11, 1'b0, 1'b0);
      step(3);
      chk(rx_valid_o == 1'b1 && rx_byte_o == 8'h11, "R5", "byte held",
          rx_byte_o, 8'h11);
      rx_q.push_back({1'b1, 8'h22});
      ecp_data_i = 8'h22;
      host_ack_i = 1'b0;
      host_clk_i = 1'b0;
      step(8);
      chk(periph_ack_o == 1'b0, "R5", "no ack while full", periph_ack_o, 0);
      chk(rx_byte_o == 8'h11, "R5", "byte stable", rx_byte_o, 8'h11);
      rx_ready_i = 1'b1;
      step(3);
      chk(periph_ack_o == 1'b1, "R5", "ack after drain", periph_ack_o, 1);
      host_clk_i = 1'b1;
      step(4);

      // R8 R6 skip while forward, then reverse
      fork
         tx_push(8'h5A, 1'b0);
         begin
            for (int i = 0; i < 10; i++) begin
               step(1);
               chk(tx_ready_o == 1'b0, "R8", "not ready in forward", tx_ready_o, 0);
               chk(ecp_data_oe == 1'b0, "R8", "bus idle in forward", ecp_data_oe, 0);
            end
            rev_req_n_i = 1'b0;
            step(2);
            chk(ack_rev_n_o == 1'b1, "R6", "ack reverse not early", ack_rev_n_o, 1);
            step(1);
            chk(ack_rev_n_o == 1'b0, "R6", "ack reverse low", ack_rev_n_o, 0);
            chk(ecp_data_oe == 1'b0, "R6", "bus still input", ecp_data_oe, 0);
            rev_host();
         end
      join

      // R9 command byte in reverse
      fork
         tx_push(8'hC3, 1'b1);
         rev_host();
      join

      // R11 abort in the middle of a reverse byte
      fork
         tx_push(8'h77, 1'b0);
         begin
            int n;
            n = 0;
            while (periph_clk_o !== 1'b0 && n < 100) begin step(1); n++; end
            void'(tx_q.pop_front());
            rev_req_n_i = 1'b1;
            step(2);
            chk(ecp_data_oe == 1'b1, "R11", "bus held before sync", ecp_data_oe, 1);
            step(1);
            chk(ecp_data_oe == 1'b0, "R11", "bus released", ecp_data_oe, 0);
            chk(periph_clk_o == 1'b1, "R11", "periph clk high", periph_clk_o, 1);
            chk(periph_ack_o == 1'b0, "R11", "periph ack low", periph_ack_o, 0);
            chk(ack_rev_n_o == 1'b1, "R11", "ack reverse high", ack_rev_n_o, 1);
            chk(rev_abort_o == 1'b1, "R11", "abort pulse", rev_abort_o, 1);
            step(1);
            chk(rev_abort_o == 1'b0, "R11", "abort pulse ends", rev_abort_o, 0);
         end
      join
      step(3);

      // R7 forward timeout on turnaround
      ecp_data_i = 8'h99;
      host_ack_i = 1'b1;
      host_clk_i = 1'b0;
      step(3);
      chk(periph_ack_o == 1'b1, "R7", "ack before timeout", periph_ack_o, 1);
      rev_req_n_i = 1'b0;
      step(3);
      chk(periph_ack_o == 1'b0, "R7", "ack dropped", periph_ack_o, 0);
      chk(ack_rev_n_o == 1'b0, "R7", "reverse acknowledged", ack_rev_n_o, 0);
      host_clk_i = 1'b1;
      step(3);
      chk(rx_valid_o == 1'b0, "R7", "no byte delivered", rx_valid_o, 0);
      rev_req_n_i = 1'b1;
      step(5);

      chk(rx_q.size() == 0, "R3", "all forward bytes seen", rx_q.size(), 0);
      summary();
   end
endmodule